// File: doc/BRIEF.md
# Multiplexed Register-ALU Datapath

This block is the datapath of a 32-bit processor that a microsequencer drives one cycle at a time. It contains a 32 x 32-bit register file, an instruction register, a program counter, a memory address register and a temporary register T that captures the ALU result. Every multiplexer input choice and every register load has its own bit in a flat control vector. The sequencer changes that vector just after the rising clock edge. Selection logic settles during the high half of the cycle, and each register whose load bit is set captures its new value on the falling edge of the same cycle.

Operand fields come from the instruction register in three layouts. All three start with a 5-bit opcode and a 5-bit first register number. The long form carries a 22-bit address. The displacement form carries a second register number and a 17-bit signed immediate. The extended form carries three register numbers and a 12-bit sub-opcode. The datapath drives a word-addressed memory port: the address comes from MAR and the write data from T. It also returns equal, less-than and greater-than flags that compare ALU port 1 with zero, so the sequencer can make conditional branches.

Top module: `regalu_datapath`

## Requirements
- R1: Synchronous active-high reset, sampled on the falling edge, clears the PC, MAR, T, IR and all 32 registers. After reset, mem_addr, mem_wdata and ir_q read zero.
- R2: All state registers change only on the falling clock edge. A register whose load bit is low keeps its value. Between a rising edge and the following falling edge, mem_addr, mem_wdata and ir_q hold their previous values.
- R3: Instruction fields, bit 31 first: op [31:27], r1 [26:22], r2 [21:17], r3 [16:12], xop [11:0], ads [21:0], im [16:0]. The im field is sign-extended to 32 bits and ads is zero-extended.
- R4: ALU port 1 takes R[r1] (bit 0) or R[r2] (bit 1). Port 2 takes R[r3] (bit 2) or the extended im (bit 3).
- R5: The MAR source takes ads (bit 4), PC (bit 5) or T (bit 6). The PC source takes PC+1 (bit 7), ads (bit 8) or port 1 (bit 9). In any select group, a group with no bit set yields zero, and several set bits are ORed together.
- R6: The register write data takes the memory bus (bit 10), T (bit 11), zero-extended PC (bit 12) or zero-extended ads (bit 13). It is written to R[r1] when bit 31 is set.
- R7: Bits 14..24 choose, in order, add, sub, mul (low 32 bits), unsigned div, and, or, xor, shift left, logical shift right, pass port 1, pass port 2. When several are set, the lowest wins. When none is set and bit 25 is low, the result is zero.
- R8: When bit 25 is set, the function code comes from a table: xop[3:0] when op is 1, otherwise op[3:0]. The code uses the numbering of R7 (0 = add ... 10 = pass port 2), and a code above 10 means add.
- R9: Division by zero gives all ones. Shifts use only the low 5 bits of port 2.
- R10: mem_rd follows bit 26 and mem_wr follows bit 27. mem_addr is MAR and mem_wdata is T. The memory bus carries mem_rdata only while bit 26 is set, and zero otherwise.
- R11: Exactly one of flag_eq, flag_lt and flag_gt is high. Each reflects the signed comparison of port 1 with zero.
- R12: Load bits: bit 28 loads MAR, 29 loads PC, 30 loads IR from the memory bus, 31 writes the register file, 32 loads T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state latches on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 33 | Control vector from the sequencer |
| mem_rdata | input | 32 | Word read from memory at mem_addr |
| mem_addr | output | 22 | Memory word address (MAR) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data (T) |
| ir_q | output | 32 | Instruction register, for decode |
| flag_eq | output | 1 | Port 1 equals zero |
| flag_lt | output | 1 | Port 1 negative |
| flag_gt | output | 1 | Port 1 positive |

## Verification
The bench runs real microcode sequences (fetch, register loads, ALU register and immediate forms, store, displacement load, call and return) against a behavioural model and compares every output on every cycle. It targets the following corner cases and the failure each one would expose:
- A negative 17-bit immediate would add a large positive number if it were not sign-extended.
- A shift count of 33 would clear the result if all of the count bits were used.
- Division by a zero register would not return all ones.
- Two function bits set at once would pick the wrong winner under a wrong priority order.
- An empty MAR select group would leave a stale address instead of zero.
- A load of IR without a read strobe would capture memory data instead of zero.
- A latch on the rising edge would show up in the mid-cycle samples.

// File: rtl/rad_pkg.sv
package rad_pkg;

    localparam int DW     = 32;
    localparam int ADS_W  = 22;
    localparam int IMM_W  = 17;
    localparam int NFN    = 11;
    localparam logic [4:0] OP_XALU = 5'd1;

    // control vector bit positions
    localparam int C_P1_R1   = 0;
    localparam int C_P1_R2   = 1;
    localparam int C_P2_RF   = 2;
    localparam int C_P2_IM   = 3;
    localparam int C_MAR_ADS = 4;
    localparam int C_PC_INC  = 7;
    localparam int C_RIN_MEM = 10;
    localparam int C_FN0     = 14;
    localparam int C_FN_TAB  = 25;
    localparam int C_MRD     = 26;
    localparam int C_MWR     = 27;
    localparam int C_LD_MAR  = 28;
    localparam int C_LD_PC   = 29;
    localparam int C_LD_IR   = 30;
    localparam int C_LD_REG  = 31;
    localparam int C_LD_T    = 32;
    localparam int CTRL_W    = 33;

    typedef enum logic [3:0] {
        FN_ADD = 4'd0, FN_SUB = 4'd1, FN_MUL = 4'd2, FN_DIV = 4'd3,
        FN_AND = 4'd4, FN_OR = 4'd5, FN_XOR = 4'd6, FN_SHL = 4'd7,
        FN_SHR = 4'd8, FN_PA = 4'd9, FN_PB = 4'd10, FN_ZERO = 4'd15
    } alu_fn_e;

    typedef struct packed {
        logic [4:0]  op;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [4:0]  rc;
        logic [11:0] xop;
    } instr_t;

    function automatic logic [DW-1:0] imm_ext(input instr_t ir);
        logic [DW-1:0] v;
        v = DW'({ir.rc, ir.xop});
        return {{(DW-IMM_W){v[IMM_W-1]}}, v[IMM_W-1:0]};
    endfunction

    function automatic logic [DW-1:0] ads_ext(input instr_t ir);
        logic [DW-1:0] v;
        v = DW'({ir.rb, ir.rc, ir.xop});
        return {{(DW-ADS_W){1'b0}}, v[ADS_W-1:0]};
    endfunction

    function automatic alu_fn_e fn_pick(input logic [NFN-1:0] bits, input logic tab,
                                        input instr_t ir);
        logic [3:0] code;
        alu_fn_e    fn;
        if (tab) begin
            code = (ir.op == OP_XALU) ? ir.xop[3:0] : ir.op[3:0];
            fn   = (code < 4'(NFN)) ? alu_fn_e'(code) : FN_ADD;
        end else begin
            fn = FN_ZERO;
            for (int i = NFN - 1; i >= 0; i--)
                if (bits[i]) fn = alu_fn_e'(4'(i));
        end
        return fn;
    endfunction

endpackage

// File: rtl/rad_selor.sv
module rad_selor #(
    parameter int N = 2,
    parameter int W = 32
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] din,
    output logic [W-1:0]   dout
);
    logic [W-1:0] terms [N];

    for (genvar i = 0; i < N; i++) begin : g_term
        assign terms[i] = din[i*W +: W] & {W{sel[i]}};
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) dout = dout | terms[i];
    end
endmodule

// File: rtl/rad_regfile.sv
module rad_regfile #(
    parameter int W  = 32,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ra,
    input  logic [IW-1:0] rb,
    input  logic [IW-1:0] rc,
    output logic [W-1:0]  qa,
    output logic [W-1:0]  qb,
    output logic [W-1:0]  qc
);
    localparam int NREG = 1 << IW;

    logic [W-1:0] rf [NREG];

    always_ff @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) rf[i] <= '0;
        end else if (we) begin
            rf[waddr] <= wdata;
        end
    end

    assign qa = rf[ra];
    assign qb = rf[rb];
    assign qc = rf[rc];

    // R6
    reg_write_chk: assert property (@(negedge clk) disable iff (rst)
        we |=> rf[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/rad_alu.sv
module rad_alu
    import rad_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y
);
    localparam int SW = $clog2(W);

    always_comb begin
        case (fn)
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_MUL:  y = a * b;
            FN_DIV:  y = (b == '0) ? '1 : a / b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_SHL:  y = a << b[SW-1:0];
            FN_SHR:  y = a >> b[SW-1:0];
            FN_PA:   y = a;
            FN_PB:   y = b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/regalu_datapath.sv
module regalu_datapath
    import rad_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [DW-1:0]     mem_rdata,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DW-1:0]     mem_wdata,
    output logic [DW-1:0]     ir_q,
    output logic              flag_eq,
    output logic              flag_lt,
    output logic              flag_gt
);
    instr_t        ir_r;
    logic [AW-1:0] pc_r, mar_r;
    logic [DW-1:0] t_r;

    logic [DW-1:0] qa, qb, qc, port1, port2, alu_y, mbus, rin, ads_w, pc_w;
    logic [AW-1:0] mar_nx, pc_nx, pc_inc;
    alu_fn_e       alu_fn;

    assign ads_w  = ads_ext(ir_r);
    assign pc_w   = DW'(pc_r);
    assign pc_inc = pc_r + AW'(1);
    assign mbus   = ctrl[C_MRD] ? mem_rdata : '0;

    rad_regfile #(.W(DW), .IW(5)) u_rf (
        .clk(clk), .rst(rst), .we(ctrl[C_LD_REG]), .waddr(ir_r.ra), .wdata(rin),
        .ra(ir_r.ra), .rb(ir_r.rb), .rc(ir_r.rc), .qa(qa), .qb(qb), .qc(qc)
    );

    rad_selor #(.N(2), .W(DW)) u_p1 (
        .sel(ctrl[C_P1_R1 +: 2]), .din({qb, qa}), .dout(port1));

    rad_selor #(.N(2), .W(DW)) u_p2 (
        .sel(ctrl[C_P2_RF +: 2]), .din({imm_ext(ir_r), qc}), .dout(port2));

    rad_selor #(.N(3), .W(AW)) u_marsel (
        .sel(ctrl[C_MAR_ADS +: 3]), .din({t_r[AW-1:0], pc_r, ads_w[AW-1:0]}), .dout(mar_nx));

    rad_selor #(.N(3), .W(AW)) u_pcsel (
        .sel(ctrl[C_PC_INC +: 3]), .din({port1[AW-1:0], ads_w[AW-1:0], pc_inc}), .dout(pc_nx));

    rad_selor #(.N(4), .W(DW)) u_rinsel (
        .sel(ctrl[C_RIN_MEM +: 4]), .din({ads_w, pc_w, t_r, mbus}), .dout(rin));

    assign alu_fn = fn_pick(ctrl[C_FN0 +: NFN], ctrl[C_FN_TAB], ir_r);

    rad_alu #(.W(DW)) u_alu (.a(port1), .b(port2), .fn(alu_fn), .y(alu_y));

    always_ff @(negedge clk) begin
        if (rst) begin
            ir_r  <= '0;
            pc_r  <= '0;
            mar_r <= '0;
            t_r   <= '0;
        end else begin
            if (ctrl[C_LD_IR])  ir_r  <= instr_t'(mbus);
            if (ctrl[C_LD_PC])  pc_r  <= pc_nx;
            if (ctrl[C_LD_MAR]) mar_r <= mar_nx;
            if (ctrl[C_LD_T])   t_r   <= alu_y;
        end
    end

    assign mem_addr  = mar_r;
    assign mem_wdata = t_r;
    assign mem_rd    = ctrl[C_MRD];
    assign mem_wr    = ctrl[C_MWR];
    assign ir_q      = ir_r;

    assign flag_eq = (port1 == '0);
    assign flag_lt = port1[DW-1];
    assign flag_gt = !port1[DW-1] && (port1 != '0);

    // R2
    mar_hold_chk: assert property (@(negedge clk) disable iff (rst)
        !ctrl[C_LD_MAR] |=> $stable(mar_r));

    // R5
    pc_step_chk: assert property (@(negedge clk) disable iff (rst)
        (ctrl[C_LD_PC] && ctrl[C_PC_INC +: 3] == 3'b001) |=> pc_r == $past(pc_r) + AW'(1));

    // R9
    div_zero_chk: assert property (@(negedge clk) disable iff (rst)
        (alu_fn == FN_DIV && port2 == '0) |-> alu_y == '1);

    // R11
    flag_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({flag_eq, flag_lt, flag_gt}) == 1);
endmodule

// File: tb/tb_regalu_datapath.sv
module tb_regalu_datapath;
    // control bit positions per R4..R12
    localparam int P1A = 0, P1B = 1, P2R = 2, P2I = 3, MADS = 4, MPC = 5, MT = 6;
    localparam int PINC = 7, PADS = 8, PP1 = 9, RMEM = 10, RT = 11, RPC = 12, RADS = 13;
    localparam int F0 = 14, FTAB = 25, MRD = 26, MWR = 27;
    localparam int LMAR = 28, LPC = 29, LIR = 30, LREG = 31, LT = 32;

    logic        clk = 1'b0, rst = 1'b1;
    logic [32:0] ctrl = '0;
    logic [31:0] mem_rdata, mem_wdata, ir_q;
    logic [21:0] mem_addr;
    logic        mem_rd, mem_wr, flag_eq, flag_lt, flag_gt;

    int checks = 0, errors = 0;

    logic [31:0] env_mem [64];
    logic [31:0] m_mem [64];
    logic [31:0] m_r [32];
    logic [31:0] m_ir, m_t;
    logic [21:0] m_pc, m_mar;

    always #5 clk = ~clk;

    regalu_datapath dut (
        .clk(clk), .rst(rst), .ctrl(ctrl), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .ir_q(ir_q),
        .flag_eq(flag_eq), .flag_lt(flag_lt), .flag_gt(flag_gt));

    assign mem_rdata = env_mem[mem_addr[5:0]];
    always @(negedge clk) if (mem_wr) env_mem[mem_addr[5:0]] <= mem_wdata;

    function automatic logic [32:0] b(input int i);
        return 33'(1) << i;
    endfunction

    function automatic logic [31:0] mk_l(input int op, input int r1, input int ads);
        return {5'(op), 5'(r1), 22'(ads)};
    endfunction
    function automatic logic [31:0] mk_d(input int op, input int r1, input int r2, input int im);
        return {5'(op), 5'(r1), 5'(r2), 17'(im)};
    endfunction
    function automatic logic [31:0] mk_x(input int op, input int r1, input int r2, input int r3,
                                         input int xop);
        return {5'(op), 5'(r1), 5'(r2), 5'(r3), 12'(xop)};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_port1(input logic [32:0] c);
        logic [31:0] v = '0;
        if (c[P1A]) v = v | m_r[m_ir[26:22]];
        if (c[P1B]) v = v | m_r[m_ir[21:17]];
        return v;
    endfunction

    function automatic logic [31:0] m_port2(input logic [32:0] c);
        logic [31:0] v = '0;
        if (c[P2R]) v = v | m_r[m_ir[16:12]];
        if (c[P2I]) v = v | {{15{m_ir[16]}}, m_ir[16:0]};
        return v;
    endfunction

    function automatic int m_code(input logic [32:0] c);
        int code;
        if (c[FTAB]) begin
            code = (m_ir[31:27] == 5'd1) ? int'(m_ir[3:0]) : int'(m_ir[30:27]);
            return (code > 10) ? 0 : code;
        end
        for (int i = 0; i <= 10; i++) if (c[F0+i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] m_alu(input int code, input logic [31:0] x, input logic [31:0] y);
        case (code)
            0: return x + y;
            1: return x - y;
            2: return x * y;
            3: return (y == 0) ? 32'hFFFF_FFFF : x / y;
            4: return x & y;
            5: return x | y;
            6: return x ^ y;
            7: return x << y[4:0];
            8: return x >> y[4:0];
            9: return x;
            10: return y;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_edge(input logic [32:0] c);
        logic [31:0] p1, y, mbus, rin, ads;
        logic [21:0] mar_n, pc_n;
        ads   = {10'b0, m_ir[21:0]};
        p1    = m_port1(c);
        y     = m_alu(m_code(c), p1, m_port2(c));
        mbus  = c[MRD] ? m_mem[m_mar[5:0]] : 32'h0;
        mar_n = '0;
        if (c[MADS]) mar_n = mar_n | ads[21:0];
        if (c[MPC])  mar_n = mar_n | m_pc;
        if (c[MT])   mar_n = mar_n | m_t[21:0];
        pc_n = '0;
        if (c[PINC]) pc_n = pc_n | (m_pc + 22'd1);
        if (c[PADS]) pc_n = pc_n | ads[21:0];
        if (c[PP1])  pc_n = pc_n | p1[21:0];
        rin = '0;
        if (c[RMEM]) rin = rin | mbus;
        if (c[RT])   rin = rin | m_t;
        if (c[RPC])  rin = rin | {10'b0, m_pc};
        if (c[RADS]) rin = rin | ads;
        if (c[MWR])  m_mem[m_mar[5:0]] = m_t;
        if (c[LREG]) m_r[m_ir[26:22]] = rin;
        if (c[LIR])  m_ir = mbus;
        if (c[LPC])  m_pc = pc_n;
        if (c[LMAR]) m_mar = mar_n;
        if (c[LT])   m_t = y;
    endtask

    task automatic step(input logic [32:0] c, input string tag);
        logic [31:0] p1;
        @(posedge clk);
        #1 ctrl = c;
        #1;
        check("R2", {tag, " mid addr"}, 32'(mem_addr), 32'(m_mar));
        check("R2", {tag, " mid T"}, mem_wdata, m_t);
        @(negedge clk);
        model_edge(c);
        #2;
        check(tag, "addr", 32'(mem_addr), 32'(m_mar));
        check(tag, "T", mem_wdata, m_t);
        check(tag, "IR", ir_q, m_ir);
        check("R10", {tag, " strobes"}, {30'b0, mem_rd, mem_wr}, {30'b0, c[MRD], c[MWR]});
        p1 = m_port1(c);
        check("R11", {tag, " flags"}, {29'b0, flag_eq, flag_lt, flag_gt},
              {29'b0, p1 == 0, p1[31], !p1[31] && p1 != 0});
    endtask

    task automatic fetch();
        step(b(MPC) | b(LMAR) | b(PINC) | b(LPC), "R12");
        step(b(MRD) | b(LIR), "R3");
    endtask

    initial begin
        logic [31:0] prog [12];
        prog[0]  = mk_l(2, 1, 100);
        prog[1]  = mk_l(2, 2, 7);
        prog[2]  = mk_l(2, 7, 33);
        prog[3]  = mk_x(1, 3, 1, 2, 1);
        prog[4]  = mk_l(3, 3, 40);
        prog[5]  = mk_d(4, 4, 1, -5);
        prog[6]  = mk_x(1, 5, 1, 6, 3);
        prog[7]  = mk_x(1, 8, 1, 7, 7);
        prog[8]  = mk_d(6, 10, 0, 40);
        prog[9]  = mk_l(5, 9, 20);
        prog[10] = mk_x(1, 11, 10, 4, 0);
        prog[11] = mk_l(3, 5, 0);
        for (int i = 0; i < 64; i++) begin
            env_mem[i] = (i < 12) ? prog[i] : 32'h0;
            m_mem[i]   = env_mem[i];
        end
        for (int i = 0; i < 32; i++) m_r[i] = '0;
        m_ir = '0; m_t = '0; m_pc = '0; m_mar = '0;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #5;
        check("R1", "reset addr", 32'(mem_addr), 32'h0);
        check("R1", "reset T", mem_wdata, 32'h0);
        check("R1", "reset IR", ir_q, 32'h0);
        check("R1", "reset eq flag", {31'b0, flag_eq}, 32'h1);

        // three immediate register loads
        for (int k = 0; k < 3; k++) begin
            fetch();
            step(b(RADS) | b(LREG), "R6");
        end
        // table-driven sub: R3 = 100 - 7
        fetch();
        step(b(P1B) | b(P2R) | b(FTAB) | b(LT), "R8");
        step(b(RT) | b(LREG), "R6");
        // store R3 at 40
        fetch();
        step(b(MADS) | b(LMAR) | b(P1A) | b(F0+9) | b(LT), "R5");
        step(b(MWR), "R10");
        // explicit add with negative immediate: R4 = 100 + (-5)
        fetch();
        step(b(P1B) | b(P2I) | b(F0+0) | b(LT), "R4");
        step(b(RT) | b(LREG), "R6");
        // divide by zero register
        fetch();
        step(b(P1B) | b(P2R) | b(FTAB) | b(LT), "R9");
        step(b(RT) | b(LREG), "R9");
        // shift by 33 uses low 5 bits
        fetch();
        step(b(P1B) | b(P2R) | b(FTAB) | b(LT), "R9");
        step(b(RT) | b(LREG), "R9");
        // displacement load R10 = M[R0 + 40]
        fetch();
        step(b(P1B) | b(P2I) | b(F0) | b(LT), "R3");
        step(b(MT) | b(LMAR), "R5");
        step(b(MRD) | b(RMEM) | b(LREG), "R10");
        step(b(P1A) | b(F0+9) | b(LT), "R10");
        // call and return
        fetch();
        step(b(RPC) | b(LREG) | b(PADS) | b(LPC), "R6");
        step(b(P1A) | b(PP1) | b(LPC), "R5");
        // priority among function bits: sub beats mul
        fetch();
        step(b(P1B) | b(P2R) | b(F0+1) | b(F0+2) | b(LT), "R7");
        step(b(P2R) | b(F0+10) | b(LT), "R7");
        step(b(P1B) | b(P2R) | b(LT), "R7");
        // empty MAR group and held registers
        step(b(LMAR), "R5");
        step(b(P1A), "R2");
        // negative port 1 for flags
        fetch();
        step(b(P1A) | b(F0+9) | b(LT), "R11");
        // IR load without read strobe sees a zero bus
        step(b(LIR), "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule